// File: doc/BRIEF.md
# Disk Command Dispatcher with Sense Tracking

This block sits behind the command intake of a small fixed-disk controller. After the six-byte command block has been collected, the opcode, the drive select and the requested cylinder are presented together with a one-cycle start strobe. The block then runs the commands that move no sector data: drive-ready test, recalibrate, seek, sense read-back and three diagnostic commands. It rejects every other opcode.

For each drive it tracks the current head cylinder. It keeps one sense register that records the most recent error cause. At the end of every command it pulses a completion strobe and presents a completion byte. A sense read-back first streams a four-byte reply, one byte per cycle, and then completes. Each drive's present flag and configured cylinder count are static inputs. Only one command runs at a time.

Top module: `disk_cmd_dispatch`

## Requirements
- R1: Opcodes 0x00 (ready test), 0x01 (recalibrate), 0x03 (sense read), 0x0B (seek), 0xE0, 0xE3 and 0xE4 (diagnostics) are accepted. Any other opcode completes with the error bit set and the sense register set to 0x20.
- R2: The completion byte has bit 5 set when the selected drive is nonzero and bit 1 set when the command failed. All its other bits are 0.
- R3: A ready test or a recalibrate on a drive whose present flag is 0 sets the error bit and sense 0x04, and leaves that drive's cylinder unchanged.
- R4: A recalibrate on a present drive sets that drive's cylinder to 0, with no error.
- R5: A seek on a present drive to a cylinder below the drive's configured count moves the drive to that cylinder, with no error. A request at or above the count moves the drive to count-1, sets the error bit and sets sense 0x15.
- R6: A sense read streams four bytes on reply_data while reply_valid is high: the sense value, then 0x20 for a nonzero drive or 0x00 for drive 0, then 0x00, then 0x00. It then completes without error, and the sense register reads 0x00.
- R7: A command that succeeds leaves the sense register unchanged. Only a sense read clears it.
- R8: Latency from the start edge to the completion strobe is LAT cycles for ready test, recalibrate, seek and rejected opcodes. It is LAT*DIAG_MULT cycles for the diagnostics, which always succeed. It is LAT+4 cycles for a sense read.
- R9: A start strobe while busy is high is ignored. The running command finishes with its own result.
- R10: After reset, busy, done and reply_valid are 0, and the sense register and every cylinder read 0.
- R11: A seek on a drive whose present flag is 0 sets the error bit and sense 0x04. No cylinder changes, and the other drive's cylinder never changes for a command that selects a different drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command start strobe |
| opcode | input | 8 | Command opcode byte |
| drv_sel | input | DRV_W | Selected drive |
| cyl_req | input | CYL_W | Requested cylinder for seek |
| drv_present | input | NUM_DRIVES | Per-drive present flags |
| cyl_limit | input | NUM_DRIVES*CYL_W | Per-drive configured cylinder count, drive 0 in the low bits |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion strobe |
| comp_byte | output | 8 | Completion byte, valid with done |
| sense | output | 8 | Current sense register |
| reply_valid | output | 1 | A sense reply byte is on reply_data |
| reply_data | output | 8 | Sense reply byte |
| cur_cyl | output | NUM_DRIVES*CYL_W | Per-drive current cylinder, drive 0 in the low bits |

## Verification
The bench builds the block with two drives, 10-bit cylinders, LAT=4 and DIAG_MULT=5. With these values the diagnostic latency is 20 cycles and the sense reply ends at cycle 8, so both long and short paths are measured exactly. The 10-bit request width lets random seeks reach values both above and below the drive limits of 615 and 300, which exercises clamping on each drive. Toggling the present flags during the random phase reaches the absent-drive paths for all three drive commands.

// File: rtl/disk_cmd_pkg.sv
package disk_cmd_pkg;
  typedef enum logic [2:0] {
    K_TEST, K_RECAL, K_SENSE, K_SEEK, K_DIAG, K_BAD
  } cmd_kind_t;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REPLY} disp_state_t;

  localparam logic [7:0] SNS_NONE   = 8'h00;
  localparam logic [7:0] SNS_NOTRDY = 8'h04;
  localparam logic [7:0] SNS_SEEK   = 8'h15;
  localparam logic [7:0] SNS_BADCMD = 8'h20;

  localparam int COMP_DRV_BIT = 5;
  localparam int COMP_ERR_BIT = 1;
endpackage

// File: rtl/disk_cmd_decode.sv
module disk_cmd_decode
  import disk_cmd_pkg::*;
(
  input  logic [7:0] op,
  output cmd_kind_t  kind
);
  always_comb begin
    case (op)
      8'h00:                kind = K_TEST;
      8'h01:                kind = K_RECAL;
      8'h03:                kind = K_SENSE;
      8'h0B:                kind = K_SEEK;
      8'hE0, 8'hE3, 8'hE4:  kind = K_DIAG;
      default:              kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/disk_lat_timer.sv
module disk_lat_timer #(
  parameter int LAT       = 4,
  parameter int DIAG_MULT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic long_mode,
  output logic expire
);
  localparam int LONG_LAT = LAT * DIAG_MULT;
  localparam int CNT_W    = $clog2(LONG_LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic             running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= long_mode ? CNT_W'(LONG_LAT - 1) : CNT_W'(LAT - 1);
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign expire = running && (cnt == '0);

  // R8: expiry is a single-cycle event per load
  a_r8_expire_once: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> !expire);
endmodule

// File: rtl/disk_cyl_track.sv
module disk_cyl_track #(
  parameter int NUM_DRIVES = 2,
  parameter int CYL_W      = 10,
  localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [DRV_W-1:0]            wr_drv,
  input  logic [CYL_W-1:0]            wr_val,
  output logic [NUM_DRIVES*CYL_W-1:0] cyl_flat
);
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    logic [CYL_W-1:0] cyl_q;
    always_ff @(posedge clk) begin
      if (rst)                                    cyl_q <= '0;
      else if (wr_en && (wr_drv == DRV_W'(d)))    cyl_q <= wr_val;
    end
    assign cyl_flat[d*CYL_W +: CYL_W] = cyl_q;
  end
endmodule

// File: rtl/disk_cmd_dispatch.sv
module disk_cmd_dispatch
  import disk_cmd_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int CYL_W      = 10,
  parameter int LAT        = 4,
  parameter int DIAG_MULT  = 5,
  localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [7:0]                  opcode,
  input  logic [DRV_W-1:0]            drv_sel,
  input  logic [CYL_W-1:0]            cyl_req,
  input  logic [NUM_DRIVES-1:0]       drv_present,
  input  logic [NUM_DRIVES*CYL_W-1:0] cyl_limit,
  output logic                        busy,
  output logic                        done,
  output logic [7:0]                  comp_byte,
  output logic [7:0]                  sense,
  output logic                        reply_valid,
  output logic [7:0]                  reply_data,
  output logic [NUM_DRIVES*CYL_W-1:0] cur_cyl
);
  disp_state_t      state;
  cmd_kind_t        kind_in, kind_q;
  logic [DRV_W-1:0] drv_q;
  logic [CYL_W-1:0] req_q;
  logic [2:0]       ridx;
  logic             expire;
  logic             exec;

  disk_cmd_decode u_dec (.op(opcode), .kind(kind_in));

  disk_lat_timer #(.LAT(LAT), .DIAG_MULT(DIAG_MULT)) u_tmr (
    .clk(clk), .rst(rst),
    .load(state == S_IDLE && start),
    .long_mode(kind_in == K_DIAG),
    .expire(expire)
  );

  assign exec = (state == S_WAIT) && expire;

  // Result of the command being executed
  logic             pres;
  logic [CYL_W-1:0] lim;
  logic             err_n, sns_wr, cyl_wr;
  logic [7:0]       sns_val;
  logic [CYL_W-1:0] cyl_val;
  logic [7:0]       drv_bits;

  assign pres     = drv_present[drv_q];
  assign lim      = cyl_limit[drv_q*CYL_W +: CYL_W];
  assign drv_bits = (drv_q != '0) ? (8'd1 << COMP_DRV_BIT) : 8'h00;

  always_comb begin
    err_n   = 1'b0;
    sns_wr  = 1'b0;
    sns_val = SNS_NONE;
    cyl_wr  = 1'b0;
    cyl_val = '0;
    case (kind_q)
      K_TEST: if (!pres) begin
        err_n = 1'b1; sns_wr = 1'b1; sns_val = SNS_NOTRDY;
      end
      K_RECAL: if (!pres) begin
        err_n = 1'b1; sns_wr = 1'b1; sns_val = SNS_NOTRDY;
      end else begin
        cyl_wr = 1'b1; cyl_val = '0;
      end
      K_SEEK: if (!pres) begin
        err_n = 1'b1; sns_wr = 1'b1; sns_val = SNS_NOTRDY;
      end else if (req_q >= lim) begin
        cyl_wr = 1'b1; cyl_val = lim - 1'b1;
        err_n = 1'b1; sns_wr = 1'b1; sns_val = SNS_SEEK;
      end else begin
        cyl_wr = 1'b1; cyl_val = req_q;
      end
      K_BAD: begin
        err_n = 1'b1; sns_wr = 1'b1; sns_val = SNS_BADCMD;
      end
      default: ;
    endcase
  end

  disk_cyl_track #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W)) u_cyl (
    .clk(clk), .rst(rst),
    .wr_en(exec && cyl_wr && kind_q != K_SENSE),
    .wr_drv(drv_q), .wr_val(cyl_val),
    .cyl_flat(cur_cyl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      kind_q      <= K_TEST;
      drv_q       <= '0;
      req_q       <= '0;
      ridx        <= '0;
      done        <= 1'b0;
      comp_byte   <= 8'h00;
      sense       <= SNS_NONE;
      reply_valid <= 1'b0;
      reply_data  <= 8'h00;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          kind_q <= kind_in;
          drv_q  <= drv_sel;
          req_q  <= cyl_req;
          state  <= S_WAIT;
        end
        S_WAIT: if (expire) begin
          if (kind_q == K_SENSE) begin
            reply_valid <= 1'b1;
            reply_data  <= sense;
            ridx        <= 3'd1;
            state       <= S_REPLY;
          end else begin
            done      <= 1'b1;
            comp_byte <= drv_bits | (err_n ? (8'd1 << COMP_ERR_BIT) : 8'h00);
            if (sns_wr) sense <= sns_val;
            state     <= S_IDLE;
          end
        end
        S_REPLY: begin
          if (ridx == 3'd4) begin
            reply_valid <= 1'b0;
            reply_data  <= 8'h00;
            done        <= 1'b1;
            comp_byte   <= drv_bits;
            sense       <= SNS_NONE;
            state       <= S_IDLE;
          end else begin
            reply_data <= (ridx == 3'd1) ? drv_bits : 8'h00;
            ridx       <= ridx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  // R2: reserved completion bits stay zero
  a_r2_comp_reserved: assert property (@(posedge clk) disable iff (rst)
    done |-> ((comp_byte & 8'hDD) == 8'h00));
  // R8: completion is a single-cycle strobe
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: reply bytes only appear inside a running command
  a_r6_reply_in_cmd: assert property (@(posedge clk) disable iff (rst)
    reply_valid |-> busy);
  // R6: reply is followed directly by completion with sense cleared
  a_r6_sense_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(reply_valid) |-> (done && sense == 8'h00));
  // R9: a start while busy does not replace the latched command
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(kind_q) && $stable(drv_q) && $stable(req_q)));

  // R5: a drive never sits at or above a nonzero configured count
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_chk
    a_r5_cyl_in_range: assert property (@(posedge clk) disable iff (rst)
      (cyl_limit[d*CYL_W +: CYL_W] != '0) |->
        (cur_cyl[d*CYL_W +: CYL_W] < cyl_limit[d*CYL_W +: CYL_W] ||
         cur_cyl[d*CYL_W +: CYL_W] == '0));
  end
endmodule

// File: tb/disk_cmd_dispatch_tb.sv
module disk_cmd_dispatch_tb;
  localparam int ND = 2, CW = 10, LAT = 4, DM = 5;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic drv_sel = 1'b0;
  logic [CW-1:0] cyl_req = '0;
  logic [ND-1:0] drv_present = 2'b01;
  logic [ND*CW-1:0] cyl_limit;
  logic busy, done, reply_valid;
  logic [7:0] comp_byte, sense, reply_data;
  logic [ND*CW-1:0] cur_cyl;

  int total = 0, bad = 0;
  logic [7:0] m_sense = 8'h00;
  logic [CW-1:0] m_cyl [ND];

  assign cyl_limit = {10'd300, 10'd615};

  always #4 clk = ~clk;

  disk_cmd_dispatch #(.NUM_DRIVES(ND), .CYL_W(CW), .LAT(LAT), .DIAG_MULT(DM)) u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .drv_sel(drv_sel),
    .cyl_req(cyl_req), .drv_present(drv_present), .cyl_limit(cyl_limit),
    .busy(busy), .done(done), .comp_byte(comp_byte), .sense(sense),
    .reply_valid(reply_valid), .reply_data(reply_data), .cur_cyl(cur_cyl));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [7:0] op);
    if (op == 8'hE0 || op == 8'hE3 || op == 8'hE4) return LAT * DM;
    if (op == 8'h03) return LAT + 4;
    return LAT;
  endfunction

  task automatic run_cmd(input logic [7:0] op, input logic drv,
                         input logic [CW-1:0] req, input bit poke);
    logic err;
    logic [7:0] rep [4];
    logic [7:0] exp_rep [4];
    logic [CW-1:0] lim;
    int n, nr;
    err = 1'b0;
    lim = cyl_limit[drv*CW +: CW];
    exp_rep[0] = m_sense; exp_rep[1] = drv ? 8'h20 : 8'h00;
    exp_rep[2] = 8'h00;   exp_rep[3] = 8'h00;
    case (op)
      8'h00: if (!drv_present[drv]) begin err = 1; m_sense = 8'h04; end
      8'h01: if (!drv_present[drv]) begin err = 1; m_sense = 8'h04; end
             else m_cyl[drv] = '0;
      8'h0B: if (!drv_present[drv]) begin err = 1; m_sense = 8'h04; end
             else if (req >= lim) begin m_cyl[drv] = lim - 1'b1; err = 1; m_sense = 8'h15; end
             else m_cyl[drv] = req;
      8'h03: m_sense = 8'h00;
      8'hE0, 8'hE3, 8'hE4: ;
      default: begin err = 1; m_sense = 8'h20; end
    endcase
    @(negedge clk);
    opcode = op; drv_sel = drv; cyl_req = req; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; nr = 0;
    while (1) begin
      if (poke && n == 1) begin
        opcode = 8'h02; drv_sel = ~drv; cyl_req = 10'd7; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      n++;
      if (reply_valid && nr < 4) begin rep[nr] = reply_data; nr++; end
      if (done || n > 200) break;
    end
    start = 1'b0;
    chk(done, "R8 done seen", int'(done), 1);
    chk(n == exp_lat(op), "R8 latency", n, exp_lat(op));
    chk(comp_byte == ((drv ? 8'h20 : 8'h00) | (err ? 8'h02 : 8'h00)),
        "R2 completion byte", comp_byte, (drv ? 8'h20 : 8'h00) | (err ? 8'h02 : 8'h00));
    chk(sense == m_sense, "R7 sense register", sense, m_sense);
    for (int d = 0; d < ND; d++)
      chk(cur_cyl[d*CW +: CW] == m_cyl[d], "R11 cylinder", cur_cyl[d*CW +: CW], m_cyl[d]);
    if (op == 8'h03) begin
      chk(nr == 4, "R6 reply count", nr, 4);
      for (int i = 0; i < 4; i++)
        if (i < nr) chk(rep[i] == exp_rep[i], "R6 reply byte", rep[i], exp_rep[i]);
    end else
      chk(nr == 0, "R6 no reply", nr, 0);
    @(negedge clk);
    chk(!busy, "R9 idle after", int'(busy), 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] ops [10];
    int seed;
    seed = 32'h1d2c;
    void'($urandom(seed));
    ops = '{8'h00, 8'h01, 8'h03, 8'h0B, 8'h0B, 8'hE0, 8'hE3, 8'hE4, 8'h02, 8'h0B};
    for (int d = 0; d < ND; d++) m_cyl[d] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !reply_valid, "R10 reset flags", {busy, done, reply_valid}, 0);
    chk(sense == 8'h00, "R10 reset sense", sense, 0);
    chk(cur_cyl == '0, "R10 reset cylinders", cur_cyl, 0);

    run_cmd(8'h00, 1'b0, 10'd0, 0);    // R3 present drive ready
    run_cmd(8'h00, 1'b1, 10'd0, 0);    // R3 absent drive
    run_cmd(8'h03, 1'b1, 10'd0, 0);    // R6 reply carries 0x04
    run_cmd(8'h03, 1'b0, 10'd0, 0);    // R6 cleared sense reads 0
    run_cmd(8'h0B, 1'b0, 10'd500, 0);  // R5 in range
    run_cmd(8'h0B, 1'b0, 10'd615, 0);  // R5 at limit, clamp to 614
    run_cmd(8'h0B, 1'b0, 10'd1023, 0); // R5 far beyond
    run_cmd(8'h0B, 1'b0, 10'd614, 0);  // R7 success keeps 0x15
    run_cmd(8'h01, 1'b0, 10'd0, 0);    // R4 recalibrate
    run_cmd(8'h01, 1'b1, 10'd0, 0);    // R3 recalibrate absent
    run_cmd(8'h0B, 1'b1, 10'd10, 0);   // R11 seek absent
    run_cmd(8'h02, 1'b0, 10'd0, 0);    // R1 rejected opcode
    run_cmd(8'hFF, 1'b1, 10'd0, 0);    // R1 rejected opcode
    run_cmd(8'hE3, 1'b0, 10'd0, 0);    // R8 diagnostic latency
    run_cmd(8'h0B, 1'b0, 10'd33, 1);   // R9 start while busy ignored
    run_cmd(8'hE4, 1'b1, 10'd0, 1);    // R9 during long command
    drv_present = 2'b11;
    run_cmd(8'h0B, 1'b1, 10'd299, 0);  // R5 drive 1 top cylinder
    run_cmd(8'h0B, 1'b1, 10'd300, 0);  // R5 drive 1 clamp

    for (int k = 0; k < 150; k++) begin
      logic [7:0] op;
      op = ops[$urandom_range(0, 9)];
      if ($urandom_range(0, 9) == 0) op = 8'($urandom());
      if ($urandom_range(0, 7) == 0) drv_present = 2'($urandom());
      run_cmd(op, 1'($urandom()), 10'($urandom()), $urandom_range(0, 5) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule